// File: doc/BRIEF.md
# Four-Way Key-Value GET Lookup Engine

This block serves key-value GET requests without any software involvement. A request begins with a header that gives an operation code and a key length. For a well-formed GET, the key then arrives as a byte stream, one byte per cycle. The engine folds the key into a 64-bit identifier. The low bits of that identifier select a bucket of four slots in an on-chip table, and all four slots are compared against the identifier. Each slot holds a valid bit, the identifier, a pointer and length into slab-allocated value storage, and a last-access timestamp. The value bytes themselves are never stored here.

On a hit, the engine returns the pointer, the length and the slot's previous last-access time. In the same cycle as the lookup, it writes the current timestamp into that slot. Everything the engine cannot serve goes out on a forwarding stream for software, tagged with a reason: requests that are not GET, malformed key lengths, and GET misses. Software fills and clears slots through a plain write port.

The engine handles one request at a time, so results always leave in request order. All four streams use valid/ready. A transfer happens on a rising clock edge when both valid and ready are high. Once an output asserts valid, its payload stays constant until the transfer. The header stream is not ready again until the result of the previous request has been taken.

Top module: `kv_get_engine`

## Requirements
- R1: A GET whose key length is 0 or greater than 255 consumes no key bytes. It is forwarded with reason code 1, together with its opcode and length. Lengths 1 and 255 are served normally.
- R2: The identifier starts from the seed 64'h9E3779B97F4A7C15. For each key byte, in arrival order, the accumulator is rotated left by 7 bits and then XORed with the byte placed in bits 7:0. The bucket index is the low log2(BUCKETS) bits of the identifier.
- R3: A slot matches only when its valid bit is set and its stored identifier equals the computed one. All four ways of the bucket are compared. A match returns that slot's pointer and length on the response stream.
- R4: When several ways match, the lowest-numbered way supplies the response.
- R5: A hit writes the current timestamp into the matching slot's last-access field, and the response reports the value that field held before the hit. A software install sets the field to 0.
- R6: A request whose opcode is not 0 (0 means GET) consumes no key bytes. It is forwarded with reason code 0, its opcode and length unchanged, and an identifier of 0.
- R7: A GET miss is forwarded with reason code 2 and the computed identifier, and it leaves every slot unchanged, timestamps included.
- R8: A software write sets the valid bit, identifier, pointer and length of the one slot named by bucket and way. Writing valid as 0 removes the slot from matching.
- R9: When a software write and a hit's timestamp update target the same bucket in the same cycle, the software write takes effect and the timestamp update is dropped. The lookup itself still uses the table contents from before that write.
- R10: Out of reset the header stream is ready and both output streams are idle. Response and forward payloads hold steady while valid is high and ready is low. At most one output is valid at a time, and no new header is accepted until the pending result has been taken.
- R11: The timestamp is a 32-bit counter that is 0 in reset, increases by one every cycle, and wraps silently. A hit records its value from the cycle after the last key byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Request header valid |
| hdr_ready | output | 1 | Engine idle and able to take a header |
| hdr_op | input | 2 | Operation code, 0 = GET |
| hdr_key_len | input | 9 | Key length in bytes |
| key_valid | input | 1 | Key byte valid |
| key_ready | output | 1 | Engine taking key bytes |
| key_byte | input | 8 | Key byte, first byte first |
| rsp_valid | output | 1 | Hit response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ptr | output | PTR_W | Value pointer from the matching slot |
| rsp_len | output | LEN_W | Value length from the matching slot |
| rsp_prev_stamp | output | TS_W | Last-access time held before this hit |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Software takes the forwarded request |
| fwd_op | output | 2 | Opcode of the forwarded request |
| fwd_key_len | output | 9 | Key length of the forwarded request |
| fwd_tag | output | 64 | Computed identifier (0 when not computed) |
| fwd_reason | output | 2 | 0 not GET, 1 bad length, 2 miss |
| sw_we | input | 1 | Software slot write strobe |
| sw_bucket | input | IDX_W | Bucket to write |
| sw_way | input | 2 | Way to write |
| sw_valid | input | 1 | Valid bit to store |
| sw_tag | input | 64 | Identifier to store |
| sw_ptr | input | PTR_W | Pointer to store |
| sw_len | input | LEN_W | Length to store |

## Verification
Damage to the table shows up on the first GET that touches the damaged bucket. A lost valid bit or a corrupted identifier turns into a forwarded miss that carries the exact identifier. A wrong way-priority order returns a pointer from the wrong slot. A timestamp written to the wrong slot, or at the wrong time, is invisible at that moment and becomes visible only on the next hit to the same slot, through the reported previous access time. A stuck or wrongly counting remaining-byte register shows at once as key bytes being refused early or taken too long, and the bench reports that as a hang or an identifier mismatch.

// File: rtl/kvg_pkg.sv
`timescale 1ns/1ps
package kvg_pkg;
  localparam int TAG_W   = 64;
  localparam int WAYS    = 4;
  localparam int WAY_W   = 2;
  localparam int KLEN_W  = 9;
  localparam int MAX_KEY = 255;
  localparam logic [1:0] OP_GET = 2'd0;

  typedef enum logic [1:0] {
    FWD_NOT_GET = 2'd0,
    FWD_BAD_LEN = 2'd1,
    FWD_MISS    = 2'd2
  } fwd_reason_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HASH,
    ST_LOOK,
    ST_RSP,
    ST_FWD
  } eng_state_e;

  // one folding step: rotate left, then mix the byte into the low end
  function automatic logic [TAG_W-1:0] fold_step(input logic [TAG_W-1:0] acc,
                                                 input logic [7:0] b,
                                                 input int unsigned rot);
    fold_step = ((acc << rot) | (acc >> (TAG_W - rot))) ^ {{(TAG_W-8){1'b0}}, b};
  endfunction
endpackage

// File: rtl/kvg_key_fold.sv
`timescale 1ns/1ps
module kvg_key_fold import kvg_pkg::*; #(
  parameter logic [TAG_W-1:0] SEED = 64'h9E3779B97F4A7C15,
  parameter int unsigned      ROT  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             byte_en,
  input  logic [7:0]       byte_in,
  output logic [TAG_W-1:0] acc
);
  logic [TAG_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= SEED;
    else if (byte_en) acc_q <= fold_step(acc_q, byte_in, ROT);
  end

  assign acc = acc_q;
endmodule

// File: rtl/kvg_way_match.sv
`timescale 1ns/1ps
module kvg_way_match import kvg_pkg::*; (
  input  logic [WAYS-1:0]             slot_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  slot_tag,
  input  logic [TAG_W-1:0]            probe,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = slot_valid[g] && (slot_tag[g] == probe);
  end

  // lowest-numbered matching way wins
  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (eq[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/kvg_bucket_store.sv
`timescale 1ns/1ps
module kvg_bucket_store import kvg_pkg::*; #(
  parameter int BUCKETS = 16,
  parameter int IDX_W   = $clog2(BUCKETS),
  parameter int PTR_W   = 32,
  parameter int LEN_W   = 20,
  parameter int TS_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][PTR_W-1:0]  rd_ptr,
  output logic [WAYS-1:0][LEN_W-1:0]  rd_len,
  output logic [WAYS-1:0][TS_W-1:0]   rd_stamp,
  input  logic                        touch_we,
  input  logic [IDX_W-1:0]            touch_idx,
  input  logic [WAY_W-1:0]            touch_way,
  input  logic [TS_W-1:0]             touch_stamp,
  input  logic                        sw_we,
  input  logic [IDX_W-1:0]            sw_idx,
  input  logic [WAY_W-1:0]            sw_way,
  input  logic                        sw_valid,
  input  logic [TAG_W-1:0]            sw_tag,
  input  logic [PTR_W-1:0]            sw_ptr,
  input  logic [LEN_W-1:0]            sw_len
);
  logic [WAYS-1:0]            vld_q   [BUCKETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [BUCKETS];
  logic [WAYS-1:0][PTR_W-1:0] ptr_q   [BUCKETS];
  logic [WAYS-1:0][LEN_W-1:0] len_q   [BUCKETS];
  logic [WAYS-1:0][TS_W-1:0]  stamp_q [BUCKETS];
  logic                       touch_blocked;

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_ptr   = ptr_q[rd_idx];
  assign rd_len   = len_q[rd_idx];
  assign rd_stamp = stamp_q[rd_idx];

  // software owns the whole bucket for the cycle it writes it
  assign touch_blocked = sw_we && (sw_idx == touch_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BUCKETS; b++) vld_q[b] <= '0;
    end else begin
      for (int b = 0; b < BUCKETS; b++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (sw_we && sw_idx == IDX_W'(b) && sw_way == WAY_W'(w))
            vld_q[b][w] <= sw_valid;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BUCKETS; b++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (sw_we && sw_idx == IDX_W'(b) && sw_way == WAY_W'(w)) begin
          tag_q[b][w]   <= sw_tag;
          ptr_q[b][w]   <= sw_ptr;
          len_q[b][w]   <= sw_len;
          stamp_q[b][w] <= '0;
        end else if (touch_we && !touch_blocked &&
                     touch_idx == IDX_W'(b) && touch_way == WAY_W'(w)) begin
          stamp_q[b][w] <= touch_stamp;
        end
      end
    end
  end
endmodule

// File: rtl/kv_get_engine.sv
`timescale 1ns/1ps
module kv_get_engine import kvg_pkg::*; #(
  parameter int               BUCKETS = 16,
  parameter int               IDX_W   = $clog2(BUCKETS),
  parameter int               PTR_W   = 32,
  parameter int               LEN_W   = 20,
  parameter int               TS_W    = 32,
  parameter int unsigned      ROT     = 7,
  parameter logic [63:0]      SEED    = 64'h9E3779B97F4A7C15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [1:0]        hdr_op,
  input  logic [8:0]        hdr_key_len,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [7:0]        key_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [TS_W-1:0]   rsp_prev_stamp,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [1:0]        fwd_op,
  output logic [8:0]        fwd_key_len,
  output logic [63:0]       fwd_tag,
  output logic [1:0]        fwd_reason,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_bucket,
  input  logic [1:0]        sw_way,
  input  logic              sw_valid,
  input  logic [63:0]       sw_tag,
  input  logic [PTR_W-1:0]  sw_ptr,
  input  logic [LEN_W-1:0]  sw_len
);
  eng_state_e                  state_q;
  logic [TS_W-1:0]             stamp_q;
  logic [1:0]                  op_q;
  logic [KLEN_W-1:0]           klen_q;
  logic [KLEN_W-1:0]           remain_q;
  logic [PTR_W-1:0]            rptr_q;
  logic [LEN_W-1:0]            rlen_q;
  logic [TS_W-1:0]             rprev_q;
  logic [TAG_W-1:0]            ftag_q;
  fwd_reason_e                 reason_q;

  logic                        hdr_fire, key_fire, len_bad;
  logic [TAG_W-1:0]            key_id;
  logic [IDX_W-1:0]            look_idx;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][PTR_W-1:0]  rd_ptr;
  logic [WAYS-1:0][LEN_W-1:0]  rd_len;
  logic [WAYS-1:0][TS_W-1:0]   rd_stamp;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic                        touch_we;

  assign hdr_ready = (state_q == ST_IDLE);
  assign key_ready = (state_q == ST_HASH);
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign key_fire  = key_valid && key_ready;
  assign len_bad   = (hdr_key_len == '0) || (hdr_key_len > KLEN_W'(MAX_KEY));
  assign look_idx  = key_id[IDX_W-1:0];
  assign touch_we  = (state_q == ST_LOOK) && hit;

  // free-running access clock, wraps silently
  always_ff @(posedge clk) begin
    if (rst) stamp_q <= '0;
    else     stamp_q <= stamp_q + 1'b1;
  end

  kvg_key_fold #(.SEED(SEED), .ROT(ROT)) u_fold (
    .clk     (clk),
    .rst     (rst),
    .clear   (hdr_fire),
    .byte_en (key_fire),
    .byte_in (key_byte),
    .acc     (key_id)
  );

  kvg_bucket_store #(
    .BUCKETS (BUCKETS),
    .IDX_W   (IDX_W),
    .PTR_W   (PTR_W),
    .LEN_W   (LEN_W),
    .TS_W    (TS_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (look_idx),
    .rd_valid    (rd_valid),
    .rd_tag      (rd_tag),
    .rd_ptr      (rd_ptr),
    .rd_len      (rd_len),
    .rd_stamp    (rd_stamp),
    .touch_we    (touch_we),
    .touch_idx   (look_idx),
    .touch_way   (hit_way),
    .touch_stamp (stamp_q),
    .sw_we       (sw_we),
    .sw_idx      (sw_bucket),
    .sw_way      (sw_way),
    .sw_valid    (sw_valid),
    .sw_tag      (sw_tag),
    .sw_ptr      (sw_ptr),
    .sw_len      (sw_len)
  );

  kvg_way_match u_match (
    .slot_valid (rd_valid),
    .slot_tag   (rd_tag),
    .probe      (key_id),
    .hit        (hit),
    .hit_way    (hit_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      klen_q   <= '0;
      remain_q <= '0;
      rptr_q   <= '0;
      rlen_q   <= '0;
      rprev_q  <= '0;
      ftag_q   <= '0;
      reason_q <= FWD_NOT_GET;
    end else begin
      unique case (state_q)
        ST_IDLE: if (hdr_fire) begin
          op_q     <= hdr_op;
          klen_q   <= hdr_key_len;
          remain_q <= hdr_key_len;
          ftag_q   <= '0;
          if (hdr_op != OP_GET) begin
            reason_q <= FWD_NOT_GET;
            state_q  <= ST_FWD;
          end else if (len_bad) begin
            reason_q <= FWD_BAD_LEN;
            state_q  <= ST_FWD;
          end else begin
            state_q  <= ST_HASH;
          end
        end
        ST_HASH: if (key_fire) begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == KLEN_W'(1)) state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit) begin
            rptr_q  <= rd_ptr[hit_way];
            rlen_q  <= rd_len[hit_way];
            rprev_q <= rd_stamp[hit_way];
            state_q <= ST_RSP;
          end else begin
            reason_q <= FWD_MISS;
            ftag_q   <= key_id;
            state_q  <= ST_FWD;
          end
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        ST_FWD: if (fwd_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid      = (state_q == ST_RSP);
  assign rsp_ptr        = rptr_q;
  assign rsp_len        = rlen_q;
  assign rsp_prev_stamp = rprev_q;
  assign fwd_valid      = (state_q == ST_FWD);
  assign fwd_op         = op_q;
  assign fwd_key_len    = klen_q;
  assign fwd_tag        = ftag_q;
  assign fwd_reason     = reason_q;
endmodule

// File: rtl/kvg_checker.sv
`timescale 1ns/1ps
module kvg_checker #(
  parameter int PTR_W = 32,
  parameter int LEN_W = 20,
  parameter int TS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic [1:0]        hdr_op,
  input logic [8:0]        hdr_key_len,
  input logic              key_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PTR_W-1:0]  rsp_ptr,
  input logic [LEN_W-1:0]  rsp_len,
  input logic [TS_W-1:0]   rsp_prev_stamp,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [1:0]        fwd_op,
  input logic [8:0]        fwd_key_len,
  input logic [63:0]       fwd_tag,
  input logic [1:0]        fwd_reason,
  input logic [TS_W-1:0]   ts
);
  logic hdr_fire;
  assign hdr_fire = hdr_valid && hdr_ready;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ptr) && $stable(rsp_len)
                                && $stable(rsp_prev_stamp)); // R10

  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_op) && $stable(fwd_key_len)
                                && $stable(fwd_tag) && $stable(fwd_reason)); // R10

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fwd_valid)); // R10

  AST_BUSY_NO_HDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || fwd_valid || key_ready) |-> !hdr_ready); // R10

  AST_NON_GET_FWD: assert property (@(posedge clk) disable iff (rst)
    hdr_fire && hdr_op != 2'd0 |=> fwd_valid && fwd_reason == 2'd0
                                  && fwd_op == $past(hdr_op) && fwd_tag == 64'd0); // R6

  AST_BAD_LEN_FWD: assert property (@(posedge clk) disable iff (rst)
    hdr_fire && hdr_op == 2'd0 && (hdr_key_len == 9'd0 || hdr_key_len > 9'd255)
      |=> fwd_valid && fwd_reason == 2'd1 && fwd_key_len == $past(hdr_key_len)); // R1

  AST_GOOD_LEN_HASH: assert property (@(posedge clk) disable iff (rst)
    hdr_fire && hdr_op == 2'd0 && hdr_key_len != 9'd0 && hdr_key_len <= 9'd255
      |=> key_ready); // R1

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ts == TS_W'($past(ts) + 1'b1)); // R11
endmodule

bind kv_get_engine kvg_checker #(
  .PTR_W (PTR_W),
  .LEN_W (LEN_W),
  .TS_W  (TS_W)
) u_kvg_chk (
  .clk            (clk),
  .rst            (rst),
  .hdr_valid      (hdr_valid),
  .hdr_ready      (hdr_ready),
  .hdr_op         (hdr_op),
  .hdr_key_len    (hdr_key_len),
  .key_ready      (key_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_ptr        (rsp_ptr),
  .rsp_len        (rsp_len),
  .rsp_prev_stamp (rsp_prev_stamp),
  .fwd_valid      (fwd_valid),
  .fwd_ready      (fwd_ready),
  .fwd_op         (fwd_op),
  .fwd_key_len    (fwd_key_len),
  .fwd_tag        (fwd_tag),
  .fwd_reason     (fwd_reason),
  .ts             (stamp_q)
);

// File: tb/kv_get_engine_test.sv
`timescale 1ns/1ps
module kv_get_engine_test;
  localparam int BK = 16;
  localparam int IW = 4;
  localparam int PW = 32;
  localparam int LW = 20;
  localparam int TW = 32;
  localparam logic [63:0] SEED = 64'h9E3779B97F4A7C15;

  typedef logic [7:0] kq_t[$];
  typedef struct {
    bit            is_rsp;
    logic [PW-1:0] ptr;
    logic [LW-1:0] len;
    logic [TW-1:0] prev;
    logic [1:0]    op;
    logic [8:0]    klen;
    logic [63:0]   tag;
    logic [1:0]    reason;
    int            req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0, hdr_ready;
  logic [1:0] hdr_op = '0;
  logic [8:0] hdr_key_len = '0;
  logic key_valid = 1'b0, key_ready;
  logic [7:0] key_byte = '0;
  logic rsp_valid, rsp_ready;
  logic [PW-1:0] rsp_ptr;
  logic [LW-1:0] rsp_len;
  logic [TW-1:0] rsp_prev_stamp;
  logic fwd_valid, fwd_ready;
  logic [1:0] fwd_op;
  logic [8:0] fwd_key_len;
  logic [63:0] fwd_tag;
  logic [1:0] fwd_reason;
  logic sw_we = 1'b0;
  logic [IW-1:0] sw_bucket = '0;
  logic [1:0] sw_way = '0;
  logic sw_valid = 1'b0;
  logic [63:0] sw_tag = '0;
  logic [PW-1:0] sw_ptr = '0;
  logic [LW-1:0] sw_len = '0;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [TW-1:0] tb_cnt;

  bit            m_v  [BK][4];
  logic [63:0]   m_tag[BK][4];
  logic [PW-1:0] m_ptr[BK][4];
  logic [LW-1:0] m_len[BK][4];
  logic [TW-1:0] m_st [BK][4];

  kv_get_engine #(.BUCKETS(BK), .PTR_W(PW), .LEN_W(LW), .TS_W(TW)) uut (
    .clk(clk), .rst(rst),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_op(hdr_op), .hdr_key_len(hdr_key_len),
    .key_valid(key_valid), .key_ready(key_ready), .key_byte(key_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ptr(rsp_ptr), .rsp_len(rsp_len),
    .rsp_prev_stamp(rsp_prev_stamp),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_op(fwd_op), .fwd_key_len(fwd_key_len),
    .fwd_tag(fwd_tag), .fwd_reason(fwd_reason),
    .sw_we(sw_we), .sw_bucket(sw_bucket), .sw_way(sw_way), .sw_valid(sw_valid),
    .sw_tag(sw_tag), .sw_ptr(sw_ptr), .sw_len(sw_len)
  );

  always #10 clk = ~clk;

  // R11: cycle count since reset, the value a hit must record
  always @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 1'b1;
  end

  task automatic check(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R2: identifier rule
  function automatic logic [63:0] key_id(input kq_t k);
    logic [63:0] acc = SEED;
    foreach (k[i]) acc = {acc[56:0], acc[63:57]} ^ {56'd0, k[i]};
    return acc;
  endfunction

  function automatic kq_t make_key(input int s, input int n);
    kq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'((s * 53 + i * 29 + i * i * 3 + (s >> 2)) & 255));
    return q;
  endfunction

  task automatic sw_write(input int b, input int w, input bit v, input logic [63:0] t,
                          input logic [PW-1:0] p, input logic [LW-1:0] l);
    @(negedge clk);
    sw_we = 1'b1; sw_bucket = IW'(b); sw_way = 2'(w); sw_valid = v;
    sw_tag = t; sw_ptr = p; sw_len = l;
    @(posedge clk);
    #1 sw_we = 1'b0;
    m_v[b][w] = v; m_tag[b][w] = t; m_ptr[b][w] = p; m_len[b][w] = l; m_st[b][w] = '0;
  endtask

  task automatic install(input kq_t k, input int w, input logic [PW-1:0] p, input logic [LW-1:0] l);
    logic [63:0] id = key_id(k);
    sw_write(int'(id[IW-1:0]), w, 1'b1, id, p, l);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [8:0] len);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_op = op; hdr_key_len = len;
    while (!hdr_ready) @(negedge clk);
    @(posedge clk);
    #1 hdr_valid = 1'b0;
  endtask

  // requests the engine must forward without taking key bytes (R1, R6)
  task automatic send_unserved(input logic [1:0] op, input logic [8:0] len, input int req);
    exp_t e;
    e.is_rsp = 1'b0; e.ptr = '0; e.len = '0; e.prev = '0;
    e.op = op; e.klen = len; e.tag = '0; e.reason = (op != 2'd0) ? 2'd0 : 2'd1; e.req = req;
    sb.push_back(e);
    send_hdr(op, len);
    @(negedge clk);
    check(key_ready == 1'b0, req, "key bytes requested", 64'(key_ready), 64'd0);
    check(fwd_valid == 1'b1, req, "forward not raised", 64'(fwd_valid), 64'd1);
  endtask

  task automatic send_get(input kq_t k, input int req, input bit clash = 1'b0,
                          input int cw = 0, input logic [63:0] ctag = '0,
                          input logic [PW-1:0] cptr = '0, input logic [LW-1:0] clen = '0);
    exp_t e;
    logic [63:0] id;
    logic [TW-1:0] st;
    int b, hw;
    send_hdr(2'd0, 9'(k.size()));
    foreach (k[i]) begin
      @(negedge clk);
      key_valid = 1'b1; key_byte = k[i];
      while (!key_ready) @(negedge clk);
      @(posedge clk);
    end
    #1 key_valid = 1'b0;
    st = tb_cnt;
    id = key_id(k);
    b  = int'(id[IW-1:0]);
    hw = -1;
    for (int w = 0; w < 4; w++) if (hw < 0 && m_v[b][w] && m_tag[b][w] == id) hw = w;
    e.req = req; e.op = 2'd0; e.klen = 9'(k.size());
    if (hw >= 0) begin
      e.is_rsp = 1'b1; e.ptr = m_ptr[b][hw]; e.len = m_len[b][hw]; e.prev = m_st[b][hw];
      e.tag = '0; e.reason = '0;
    end else begin
      e.is_rsp = 1'b0; e.ptr = '0; e.len = '0; e.prev = '0; e.tag = id; e.reason = 2'd2;
    end
    sb.push_back(e);
    if (clash) begin
      sw_we = 1'b1; sw_bucket = IW'(b); sw_way = 2'(cw); sw_valid = 1'b1;
      sw_tag = ctag; sw_ptr = cptr; sw_len = clen;
    end
    @(posedge clk);
    #1 sw_we = 1'b0;
    if (hw >= 0 && !clash) m_st[b][hw] = st;
    if (clash) begin
      m_v[b][cw] = 1'b1; m_tag[b][cw] = ctag; m_ptr[b][cw] = cptr;
      m_len[b][cw] = clen; m_st[b][cw] = '0;
    end
  endtask

  // monitor: pops the scoreboard as results leave, with back-pressure (R10)
  initial begin
    int ncyc = 0;
    exp_t e;
    rsp_ready = 1'b0;
    fwd_ready = 1'b0;
    forever begin
      @(negedge clk);
      ncyc++;
      rsp_ready = (ncyc % 4) != 1;
      fwd_ready = (ncyc % 5) != 2;
      if (!rst && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) check(1'b0, 10, "unexpected response", 64'd1, 64'd0);
        else begin
          e = sb.pop_front();
          check(e.is_rsp, e.req, "response instead of forward", 64'd1, 64'd0);
          if (e.is_rsp) begin
            check(rsp_ptr == e.ptr, e.req, "rsp_ptr", 64'(rsp_ptr), 64'(e.ptr));
            check(rsp_len == e.len, e.req, "rsp_len", 64'(rsp_len), 64'(e.len));
            check(rsp_prev_stamp == e.prev, e.req, "rsp_prev_stamp",
                  64'(rsp_prev_stamp), 64'(e.prev));
          end
        end
      end
      if (!rst && fwd_valid && fwd_ready) begin
        if (sb.size() == 0) check(1'b0, 10, "unexpected forward", 64'd1, 64'd0);
        else begin
          e = sb.pop_front();
          check(!e.is_rsp, e.req, "forward instead of response", 64'd0, 64'd1);
          if (!e.is_rsp) begin
            check(fwd_reason == e.reason, e.req, "fwd_reason", 64'(fwd_reason), 64'(e.reason));
            check(fwd_op == e.op, e.req, "fwd_op", 64'(fwd_op), 64'(e.op));
            check(fwd_key_len == e.klen, e.req, "fwd_key_len", 64'(fwd_key_len), 64'(e.klen));
            check(fwd_tag == e.tag, e.req, "fwd_tag", fwd_tag, e.tag);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    kq_t ka, kb, kc, kl, fk[4];
    logic [63:0] tmp;
    int found;
    for (int b = 0; b < BK; b++)
      for (int w = 0; w < 4; w++) begin
        m_v[b][w] = 1'b0; m_tag[b][w] = '0; m_ptr[b][w] = '0; m_len[b][w] = '0; m_st[b][w] = '0;
      end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(hdr_ready == 1'b1, 10, "hdr_ready after reset", 64'(hdr_ready), 64'd1);
    check(rsp_valid == 1'b0, 10, "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(fwd_valid == 1'b0, 10, "fwd_valid after reset", 64'(fwd_valid), 64'd0);
    check(key_ready == 1'b0, 10, "key_ready after reset", 64'(key_ready), 64'd0);

    ka = make_key(1, 12);
    kb = make_key(2, 30);
    kc = make_key(77, 5);
    send_get(ka, 7);                          // R7 miss on empty table, R2 tag
    install(ka, 2, 32'h1000_0A00, 20'd512);   // R8
    send_get(ka, 3);                          // R3 hit, R5 previous stamp 0
    send_get(ka, 5);                          // R5 previous stamp from first hit, R11

    send_unserved(2'd1, 9'd10, 6);            // R6
    send_unserved(2'd3, 9'd0, 6);             // R6
    send_unserved(2'd0, 9'd0, 1);             // R1 zero length
    send_unserved(2'd0, 9'd300, 1);           // R1 over-long
    send_unserved(2'd0, 9'd256, 1);           // R1 first illegal length

    kl = make_key(9, 255);
    send_get(kl, 1);                          // R1 longest key, R2 tag
    send_get(make_key(4, 1), 1);              // R1 shortest key

    tmp = key_id(kb);
    sw_write(int'(tmp[IW-1:0]), 3, 1'b1, tmp, 32'h3333_0000, 20'd33);
    sw_write(int'(tmp[IW-1:0]), 1, 1'b1, tmp, 32'h1111_0000, 20'd11);
    send_get(kb, 4);                          // R4 lowest way wins
    sw_write(int'(tmp[IW-1:0]), 1, 1'b0, tmp, 32'h0, 20'd0);
    send_get(kb, 8);                          // R8 invalidated way no longer matches
    sw_write(int'(tmp[IW-1:0]), 3, 1'b0, tmp, 32'h0, 20'd0);
    send_get(kb, 7);                          // R7 miss after full invalidate
    send_get(ka, 7);                          // R7 earlier misses left A intact

    send_get(ka, 9, 1'b1, 0, key_id(kc), 32'hCCCC_0000, 20'd7); // R9 same-bucket clash
    send_get(ka, 9);                          // R9 stamp update was dropped

    found = 0;
    for (int s = 200; s < 3000 && found < 4; s++) begin
      kq_t k = make_key(s, 6 + (s % 5));
      tmp = key_id(k);
      if (tmp[IW-1:0] == 4'd9) begin
        fk[found] = k;
        found++;
      end
    end
    for (int w = 0; w < found; w++) install(fk[w], w, 32'hF000_0000 + 32'(w), 20'(100 + w));
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < found; w++) send_get(fk[w], 3);   // R3 all four ways, R5

    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) send_get(ka, 2);        // R2
      else send_get(make_key(500 + i, 3 + i), 2);  // R2 misses carry the identifier
    end

    wait (sb.size() == 0);
    repeat (5) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule